// File: doc/BRIEF.md
# Flash Cache Access Controller

This block sits between a system bus and an execute-in-place flash port and keeps a small direct-mapped read cache of flash words. Each bus access carries a two-bit alias in the top address bits. The alias, together with a 32-bit control word, decides whether the access is looked up in the cache, sent to flash, or refused with a bus error. A separate select input opens a window that uses the cache data array as plain SRAM. That window is usable only while the cache is switched off and powered up.

The bus side handles one access at a time. `req_ready` is high only while the block is idle. Every accepted access produces exactly one `resp_valid` pulse, which may carry `resp_err`. A miss or a bypass raises `fl_req` and holds `fl_addr` until the flash side returns a word with `fl_ack`. The returned word is answered on the bus in the following cycle. If the alias allocates, the word is also written into the line.

Top module: `flash_cache_ctrl`

## Requirements
- R1: The control word read back on `cfg_rdata` carries cache enable at bit 0, bad-write fault at bit 1 and power-down at bit 3. Every other bit reads 0.
- R2: After reset the control word reads 0x00000003 and no cache line is valid.
- R3: A control write with bit 3 set leaves enable at 0, whatever bit 0 holds. While power-down is 1, enable is never 1.
- R4: With enable at 0, every flash-window read makes one flash request and allocates nothing. Writes do not change the tag store.
- R5: With enable at 1, a read in alias 0 or alias 1 whose line is valid and whose tag matches is answered from the data array, with no flash request.
- R6: A write in alias 0 with enable at 1 invalidates the line only if that line is valid and its tag matches. It gets an error-free response and never reaches flash. A line holding a different tag at the same index stays valid.
- R7: A write in alias 1, 2 or 3 is answered with `resp_err` when the fault bit is 1. When the fault bit is 0, the write gets an error-free response and changes nothing.
- R8: A cache-as-SRAM access while enable or power-down is 1 is answered with `resp_err` and leaves the data array unchanged.
- R9: With enable and power-down both 0, a cache-as-SRAM write stores its word at index addr[IDX_W+1:2], and a cache-as-SRAM read returns the word stored there.
- R10: A read miss in alias 0 with enable at 1 makes one flash request for `fl_addr` = addr[ADDR_W-3:0]. It returns the flash word and fills the line, so the next read of that address hits.
- R11: Alias 1 misses go to flash without allocating. Alias 3 reads always go to flash without allocating. Alias 2 reads always go to flash and then allocate the line.
- R12: While power-down is 1, flash-window reads still complete through flash. Tag, valid and data contents are kept, so after the cache is enabled again an earlier line still hits with its old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read back |
| req_valid | input | 1 | Bus access request |
| req_ready | output | 1 | Block idle and accepting an access |
| req_write | input | 1 | Access is a write |
| req_sram | input | 1 | Access targets the cache-as-SRAM window |
| req_addr | input | ADDR_W | Byte address, alias in the top two bits |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Response is a bus error |
| resp_rdata | output | 32 | Read data for the response |
| fl_req | output | 1 | Flash word request, held until acknowledged |
| fl_addr | output | ADDR_W-2 | Flash byte address |
| fl_ack | input | 1 | Flash word returned |
| fl_rdata | input | 32 | Flash word |

## Verification
The lookup path is driven with repeated reads of one address, and this separates a hit from a refill by counting flash requests against the reference model. Two tags that share one index are interleaved with alias-0 writes, which shows whether invalidation honours the tag compare. Each alias is used on both present and absent lines, so lookup, allocation and bypass can be told apart. The same addresses are then replayed with the cache disabled, powered down and re-enabled, which exposes any loss of stored lines or any opening of the SRAM window in the wrong state.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
   typedef enum logic [1:0] {
      ALIAS_CACHE_ALLOC = 2'd0,
      ALIAS_CACHE_ONLY  = 2'd1,
      ALIAS_ALLOC_ONLY  = 2'd2,
      ALIAS_BYPASS      = 2'd3
   } alias_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FLASH = 1'b1
   } fcc_state_e;

   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_BAD_BIT = 1;
   localparam int CFG_PD_BIT  = 3;
endpackage

// File: rtl/fcc_ctrl_reg.sv
module fcc_ctrl_reg
   import fcc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic        en,
   output logic        badwr,
   output logic        pd,
   output logic [31:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[31:4], wdata[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b1;
         badwr <= 1'b1;
         pd    <= 1'b0;
      end else if (wr_en) begin
         pd    <= wdata[CFG_PD_BIT];
         badwr <= wdata[CFG_BAD_BIT];
         en    <= wdata[CFG_EN_BIT] & ~wdata[CFG_PD_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      rdata[CFG_EN_BIT]  = en;
      rdata[CFG_BAD_BIT] = badwr;
      rdata[CFG_PD_BIT]  = pd;
   end

   AST_PD_KEEPS_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pd |-> !en); // R3
endmodule

// File: rtl/fcc_tag_store.sv
module fcc_tag_store #(
   parameter int LINES = 16,
   parameter int TAG_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
         end else if (fill_en && fill_idx == IDX_W'(i)) begin
            valid_q[i] <= 1'b1;
         end else if (inv_en && inv_idx == IDX_W'(i)) begin
            valid_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en && fill_idx == IDX_W'(i)) begin
            tag_q[i] <= fill_tag;
         end
      end
   end

   assign hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

   AST_NO_FILL_INV_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_en && inv_en)); // R6
   AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid_q[$past(fill_idx)]); // R10
endmodule

// File: rtl/fcc_data_array.sv
module fcc_data_array #(
   parameter int LINES            = 16,
   parameter int DATA_W           = 32,
   parameter bit CLEAR_ON_RESET   = 1'b0,
   localparam int IDX_W           = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [LINES];

   if (CLEAR_ON_RESET) begin : g_clear
      for (genvar i = 0; i < LINES; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q[i] <= '0;
            end else if (we && waddr == IDX_W'(i)) begin
               mem_q[i] <= wdata;
            end
         end
      end
   end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we) begin
            mem_q[waddr] <= wdata;
         end
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_cache_ctrl.sv
module flash_cache_ctrl
   import fcc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LINES  = 16,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = ADDR_W - 2,
   localparam int TAG_W  = OFF_W - IDX_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_sram,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [31:0]       resp_rdata,
   output logic              fl_req,
   output logic [OFF_W-1:0]  fl_addr,
   input  logic              fl_ack,
   input  logic [31:0]       fl_rdata
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("flash_cache_ctrl: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("flash_cache_ctrl: ADDR_W too small for LINES");
   end

   logic en, badwr, pd;
   fcc_state_e state_q;
   logic       alloc_q;
   logic [IDX_W-1:0] idx_q;
   logic [TAG_W-1:0] tag_q;

   alias_e           al;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic             hit, acc, sram_locked, lookup_alias, read_hit;
   logic             fill_en, inv_en, dat_we;
   logic [IDX_W-1:0] dat_waddr;
   logic [31:0]      dat_wdata, dat_rdata;

   fcc_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr),
      .wdata (cfg_wdata),
      .en    (en),
      .badwr (badwr),
      .pd    (pd),
      .rdata (cfg_rdata)
   );

   assign al  = alias_e'(req_addr[ADDR_W-1 -: 2]);
   assign idx = req_addr[IDX_W+1:2];
   assign tag = req_addr[OFF_W-1:IDX_W+2];

   assign req_ready    = (state_q == ST_IDLE);
   assign acc          = req_valid && req_ready;
   assign sram_locked  = en || pd;
   assign lookup_alias = (al == ALIAS_CACHE_ALLOC) || (al == ALIAS_CACHE_ONLY);
   assign read_hit     = en && lookup_alias && hit;

   fcc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (idx),
      .lk_tag   (tag),
      .hit      (hit),
      .fill_en  (fill_en),
      .fill_idx (idx_q),
      .fill_tag (tag_q),
      .inv_en   (inv_en),
      .inv_idx  (idx)
   );

   assign fill_en = (state_q == ST_FLASH) && fl_ack && alloc_q;
   assign inv_en  = acc && !req_sram && req_write && (al == ALIAS_CACHE_ALLOC) && en && hit;

   always_comb begin
      dat_we    = 1'b0;
      dat_waddr = idx;
      dat_wdata = req_wdata;
      if (fill_en) begin
         dat_we    = 1'b1;
         dat_waddr = idx_q;
         dat_wdata = fl_rdata;
      end else if (acc && req_sram && req_write && !sram_locked) begin
         dat_we = 1'b1;
      end
   end

   fcc_data_array #(.LINES(LINES), .DATA_W(32), .CLEAR_ON_RESET(1'b0)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dat_we),
      .waddr (dat_waddr),
      .wdata (dat_wdata),
      .raddr (idx),
      .rdata (dat_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
         fl_addr    <= '0;
         alloc_q    <= 1'b0;
         idx_q      <= '0;
         tag_q      <= '0;
      end else begin
         resp_valid <= 1'b0;
         if (state_q == ST_FLASH) begin
            if (fl_ack) begin
               state_q    <= ST_IDLE;
               resp_valid <= 1'b1;
               resp_err   <= 1'b0;
               resp_rdata <= fl_rdata;
            end
         end else if (acc) begin
            if (req_sram) begin
               resp_valid <= 1'b1;
               resp_err   <= sram_locked;
               resp_rdata <= (sram_locked || req_write) ? 32'h0 : dat_rdata;
            end else if (req_write) begin
               resp_valid <= 1'b1;
               resp_err   <= (al != ALIAS_CACHE_ALLOC) && badwr;
               resp_rdata <= 32'h0;
            end else if (read_hit) begin
               resp_valid <= 1'b1;
               resp_err   <= 1'b0;
               resp_rdata <= dat_rdata;
            end else begin
               state_q <= ST_FLASH;
               fl_addr <= req_addr[OFF_W-1:0];
               alloc_q <= en && ((al == ALIAS_CACHE_ALLOC) || (al == ALIAS_ALLOC_ONLY));
               idx_q   <= idx;
               tag_q   <= tag;
            end
         end
      end
   end

   assign fl_req = (state_q == ST_FLASH);

   AST_HIT_SKIPS_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_sram && !req_write && en && lookup_alias && hit |=> resp_valid && !fl_req); // R5
   AST_OFF_GOES_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_sram && !req_write && !en |=> fl_req); // R4
   AST_SRAM_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_sram && (en || pd) |=> resp_valid && resp_err); // R8
   AST_FLASH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_ack |=> fl_req && $stable(fl_addr)); // R10
   AST_BADWRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write && !req_sram && (al != ALIAS_CACHE_ALLOC) && badwr |=> resp_valid && resp_err); // R7
   AST_BYPASS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_sram && !req_write && (al == ALIAS_BYPASS) |=> fl_req && !alloc_q); // R11
endmodule

// File: tb/flash_cache_ctrl_tb_top.sv
module flash_cache_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 24;
   localparam int LINES  = 16;
   localparam int OFF_W  = ADDR_W - 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [31:0]       cfg_wdata = '0;
   logic [31:0]       cfg_rdata;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic              req_sram = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              resp_valid, resp_err;
   logic [31:0]       resp_rdata;
   logic              fl_req;
   logic [OFF_W-1:0]  fl_addr;
   logic              fl_ack = 1'b0;
   logic [31:0]       fl_rdata = '0;

   int checks = 0;
   int errors = 0;
   int flash_reads = 0;
   bit finished = 1'b0;
   bit run_cfg_check = 1'b0;

   // reference model state
   bit          m_en, m_bad, m_pd;
   bit          m_valid [LINES];
   int unsigned m_tag   [LINES];
   logic [31:0] m_data  [LINES];

   flash_cache_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_sram(req_sram), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] flash_word(input logic [OFF_W-1:0] a);
      return (32'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // flash responder: two cycles of latency per word
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge clk);
         fl_ack = 1'b0;
         if (fl_req) begin
            wait_cnt++;
            if (wait_cnt == 2) begin
               wait_cnt    = 0;
               fl_ack      = 1'b1;
               fl_rdata    = flash_word(fl_addr);
               flash_reads++;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   // control word compared with the model on every clock (R1)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (run_cfg_check) begin
            check(cfg_rdata == {28'h0, m_pd, 1'b0, m_bad, m_en}, "R1", "control readback",
                  cfg_rdata, {28'h0, m_pd, 1'b0, m_bad, m_en});
         end
      end
   end

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      m_pd  = v[3];
      m_bad = v[1];
      m_en  = v[0] && !v[3];
   endtask

   task automatic access(input bit sram, input bit wr, input logic [1:0] al,
                         input logic [OFF_W-1:0] off, input logic [31:0] wd,
                         input string req);
      bit          exp_err = 1'b0;
      int          exp_fl  = 0;
      logic [31:0] exp_dat = '0;
      int          idx = int'(off[5:2]);
      int unsigned tg  = int'(off[OFF_W-1:6]);
      int          f0;
      int          guard = 0;
      if (sram) begin
         if (m_en || m_pd) exp_err = 1'b1;
         else if (wr) m_data[idx] = wd;
         else exp_dat = m_data[idx];
      end else if (wr) begin
         if (al == 2'd0 && m_en && m_valid[idx] && m_tag[idx] == tg) m_valid[idx] = 1'b0;
         exp_err = (al != 2'd0) && m_bad;
      end else if (m_en && al < 2'd2 && m_valid[idx] && m_tag[idx] == tg) begin
         exp_dat = m_data[idx];
      end else begin
         exp_fl  = 1;
         exp_dat = flash_word(off);
         if (m_en && (al == 2'd0 || al == 2'd2)) begin
            m_valid[idx] = 1'b1;
            m_tag[idx]   = tg;
            m_data[idx]  = exp_dat;
         end
      end
      f0 = flash_reads;
      @(negedge clk);
      check(req_ready, req, "ready before access", 32'(req_ready), 32'h1);
      req_valid = 1'b1;
      req_sram  = sram;
      req_write = wr;
      req_addr  = {al, off};
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      check(resp_valid, req, "response arrives", 32'(resp_valid), 32'h1);
      check(resp_err == exp_err, req, "error flag", 32'(resp_err), 32'(exp_err));
      if (!wr && !exp_err)
         check(resp_rdata == exp_dat, req, "read data", resp_rdata, exp_dat);
      check(flash_reads - f0 == exp_fl, req, "flash requests",
            32'(flash_reads - f0), 32'(exp_fl));
   endtask

   localparam logic [OFF_W-1:0] ADDR_A = 22'h000104; // index 1
   localparam logic [OFF_W-1:0] ADDR_B = 22'h000208; // index 2, tag 8
   localparam logic [OFF_W-1:0] ADDR_C = 22'h000408; // index 2, tag 16
   localparam logic [OFF_W-1:0] ADDR_X = 22'h00003C; // index 15

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_en = 1'b1; m_bad = 1'b1; m_pd = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         m_valid[i] = 1'b0; m_tag[i] = 0; m_data[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset value
      check(cfg_rdata == 32'h3, "R2", "reset control word", cfg_rdata, 32'h3);
      run_cfg_check = 1'b1;
      // R2: no line valid after reset, so the first alias-1 read goes to flash
      access(0, 0, 2'd1, ADDR_A, '0, "R2");
      // R10: allocate on miss, then hit (R5)
      access(0, 0, 2'd0, ADDR_A, '0, "R10");
      access(0, 0, 2'd0, ADDR_A, '0, "R5");
      access(0, 0, 2'd1, ADDR_A, '0, "R5");
      // R11: alias 1 miss twice without allocation, alias 3 bypass, alias 2 allocate
      access(0, 0, 2'd1, ADDR_B, '0, "R11");
      access(0, 0, 2'd1, ADDR_B, '0, "R11");
      access(0, 0, 2'd3, ADDR_A, '0, "R11");
      access(0, 0, 2'd2, ADDR_B, '0, "R11");
      access(0, 0, 2'd1, ADDR_B, '0, "R11");
      access(0, 0, 2'd2, ADDR_B, '0, "R11");
      // R6: write with other tag at same index keeps line, matching tag invalidates
      access(0, 1, 2'd0, ADDR_C, 32'h1111_2222, "R6");
      access(0, 0, 2'd1, ADDR_B, '0, "R6");
      access(0, 1, 2'd0, ADDR_A, 32'h3333_4444, "R6");
      access(0, 0, 2'd1, ADDR_A, '0, "R6");
      access(0, 0, 2'd0, ADDR_A, '0, "R6");
      // R7: fault on non-zero aliases, then silent drop
      access(0, 1, 2'd1, ADDR_B, 32'hDEAD_0001, "R7");
      access(0, 1, 2'd3, ADDR_B, 32'hDEAD_0002, "R7");
      cfg_write(32'h0000_0001);
      access(0, 1, 2'd2, ADDR_B, 32'hDEAD_0003, "R7");
      access(0, 1, 2'd3, ADDR_B, 32'hDEAD_0004, "R7");
      access(0, 0, 2'd1, ADDR_B, '0, "R7");
      // R8: SRAM window refused while enabled, contents unchanged
      access(1, 1, 2'd0, ADDR_B, 32'hBAD0_BAD0, "R8");
      access(1, 0, 2'd0, ADDR_B, '0, "R8");
      access(0, 0, 2'd1, ADDR_B, '0, "R8");
      // R1: reserved bits are dropped on write
      cfg_write(32'hFFFF_FFF4);
      // R4: disabled, every read goes to flash and nothing allocates
      cfg_write(32'h0000_0000);
      access(0, 0, 2'd0, ADDR_B, '0, "R4");
      access(0, 0, 2'd0, ADDR_X, '0, "R4");
      access(0, 0, 2'd1, ADDR_A, '0, "R4");
      // R9: SRAM window usable while off and powered
      access(1, 1, 2'd0, ADDR_X, 32'hCAFE_F00D, "R9");
      access(1, 0, 2'd0, ADDR_X, '0, "R9");
      access(1, 0, 2'd0, ADDR_B, '0, "R9");
      // R3: power-down forces enable low
      cfg_write(32'h0000_000B);
      check(cfg_rdata == 32'h0000_000A, "R3", "enable forced low", cfg_rdata, 32'h0000_000A);
      // R12: powered-down reads bypass, SRAM refused (R8)
      access(0, 0, 2'd0, ADDR_B, '0, "R12");
      access(0, 0, 2'd2, ADDR_C, '0, "R12");
      access(1, 0, 2'd0, ADDR_X, '0, "R8");
      access(1, 1, 2'd0, ADDR_X, 32'h0BAD_0BAD, "R8");
      // R12: re-enable, earlier lines still hit with their data
      cfg_write(32'h0000_0001);
      access(0, 0, 2'd1, ADDR_B, '0, "R12");
      access(0, 0, 2'd0, ADDR_A, '0, "R12");
      access(0, 0, 2'd1, ADDR_C, '0, "R12");
      cfg_write(32'h0000_0000);
      access(1, 0, 2'd0, ADDR_X, '0, "R12");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule